// File: doc/BRIEF.md
# Received Frame CRC Checker and Sample Unpacker

This block sits behind a byte-wide receive path from a multi-channel converter that answers every transfer with a fixed-length frame. Each frame carries three-byte words in a fixed order. The response word comes first. One word per channel follows it, and a CRC word closes the frame. The block is fed one byte at a time. While the bytes stream in, it runs a CRC-16 over the response and channel words. It also builds a shadow copy of the status field and of every channel sample. When the final byte lands, it compares the CRC it computed with the CRC the frame carries. A match publishes the samples, sign-extended to 32 bits, together with the status field. A mismatch leaves the published values untouched and raises an error pulse.

A frame begins with a byte marked as start-of-frame. From there a small state machine walks through its states. `ST_IDLE` waits for a start byte. `ST_BODY` takes the response and channel words, each byte of which is folded into the CRC. `ST_CRC_HI` and `ST_CRC_LO` capture the received CRC. `ST_CRC_PAD` takes the last pad byte and makes the verdict. The transitions are as follows:
- start byte from any state → `ST_BODY` (restart);
- last body byte → `ST_CRC_HI`;
- `ST_CRC_HI` → `ST_CRC_LO` → `ST_CRC_PAD` on each accepted byte;
- pad byte → `ST_IDLE`.

Top module: `rx_frame_unpacker`

## Requirements
- R1: After reset, `frame_ok` and `frame_crc_bad` are 0 and `sample_bus` and `status_word` are all zero.
- R2: A frame starts with a byte accepted while `in_valid` and `in_sof` are both 1. That byte is byte 0. Channel x occupies bytes 3+3x, 4+3x and 5+3x, most significant byte first.
- R3: Each channel's published value is its 24-bit two's complement code, sign-extended from bit 23 to 32 bits. Channel x sits in `sample_bus[32x+31:32x]`.
- R4: The CRC uses polynomial 0x1021 with seed 0xFFFF and is processed MSB first over bytes 0 to 3N+2. Those bytes include every pad byte. The received CRC is byte 3N+3 (high) followed by byte 3N+4 (low). The final byte, 3N+5, is not checked.
- R5: On a CRC match, `frame_ok` is 1 for exactly one cycle: the cycle that follows the clock edge which accepted byte 3N+5. `sample_bus` and `status_word` take the frame's values at that same edge.
- R6: On a CRC mismatch, `frame_crc_bad` pulses in that same cycle and `frame_ok` stays 0. `sample_bus` and `status_word` keep their previous values.
- R7: `status_word` holds byte 0 in bits 15:8 and byte 1 in bits 7:0. When bit 12 (an earlier input CRC fault) is set, the frame is still published.
- R8: A start byte that arrives in the middle of a frame discards the partial frame and counts as byte 0 of a new one.
- R9: A byte offered while `in_valid` is 0 has no effect. A byte without `in_sof` that arrives while no frame is open also has no effect, and no flag rises.
- R10: `frame_ok` and `frame_crc_bad` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_sof | input | 1 | The offered byte is byte 0 of a frame |
| in_byte | input | 8 | Received byte |
| sample_bus | output | NUM_CH*32 | Sign-extended samples of the last good frame |
| status_word | output | 16 | Status field of the last good frame |
| frame_ok | output | 1 | One-cycle pulse: a frame passed the CRC |
| frame_crc_bad | output | 1 | One-cycle pulse: a frame failed the CRC |

## Verification
Two events can fall in the same cycle: the verdict on one frame and the capture of byte 0 of the next. The verdict commits the shadow samples, while the new start byte reseeds the CRC and begins overwriting the shadows. The bench provokes this by sending frames back to back with no idle cycle between them, and by sending some with random gaps. In the first cycle after each frame it checks the published samples and flags against the values modelled for that frame alone, including cases where the next frame is already in flight. Corrupted frames sit among good ones, so a held value that a following frame overwrote too early would also show up as a mismatch.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BODY,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_CRC_PAD
    } rx_state_t;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam int          SAMPLE_W = 24;
    localparam int          OUT_W    = 32;
endpackage

// File: rtl/rfu_crc_step.sv
module rfu_crc_step
    import rfu_pkg::*;
(
    input  logic [15:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [15:0] crc_out
);
    always_comb begin
        logic [15:0] acc;
        acc = crc_in ^ {data_in, 8'h00};
        for (int i = 0; i < 8; i++) begin
            if (acc[15]) acc = {acc[14:0], 1'b0} ^ CRC_POLY;
            else         acc = {acc[14:0], 1'b0};
        end
        crc_out = acc;
    end
endmodule

// File: rtl/rfu_lane_regs.sv
module rfu_lane_regs
    import rfu_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int WORD_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [WORD_W-1:0]       wr_word,
    input  logic [1:0]              wr_pos,
    input  logic [7:0]              wr_byte,
    input  logic                    commit,
    output logic [NUM_CH*OUT_W-1:0] samples
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic [SAMPLE_W-1:0] shadow;
        logic [OUT_W-1:0]    pub;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow <= '0;
            end else if (wr_en && (32'(wr_word) == g + 1)) begin
                unique case (wr_pos)
                    2'd0:    shadow[23:16] <= wr_byte;
                    2'd1:    shadow[15:8]  <= wr_byte;
                    default: shadow[7:0]   <= wr_byte;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pub <= '0;
            else if (commit) pub <= {{(OUT_W-SAMPLE_W){shadow[SAMPLE_W-1]}}, shadow};
        end

        assign samples[g*OUT_W +: OUT_W] = pub;
    end
endmodule

// File: rtl/rx_frame_unpacker.sv
module rx_frame_unpacker
    import rfu_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [7:0]              in_byte,
    output logic [NUM_CH*32-1:0]    sample_bus,
    output logic [15:0]             status_word,
    output logic                    frame_ok,
    output logic                    frame_crc_bad
);
    localparam int WORD_W = $clog2(NUM_CH + 1);
    localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(NUM_CH);

    rx_state_t         state, state_nx;
    logic [WORD_W-1:0] word_q, word_nx;
    logic [1:0]        pos_q, pos_nx;
    logic [15:0]       crc_acc, crc_base, crc_nx;
    logic [7:0]        rx_hi, rx_lo;
    logic [15:0]       stat_shadow;

    // bytes that belong to the CRC-covered body of the frame
    logic              take_body;
    logic [WORD_W-1:0] cur_word;
    logic [1:0]        cur_pos;
    logic              at_pad, crc_match;

    assign take_body = in_valid && (in_sof || state == ST_BODY);
    assign cur_word  = in_sof ? '0 : word_q;
    assign cur_pos   = in_sof ? 2'd0 : pos_q;
    assign crc_base  = in_sof ? CRC_SEED : crc_acc;
    assign at_pad    = in_valid && !in_sof && state == ST_CRC_PAD;
    assign crc_match = ({rx_hi, rx_lo} == crc_acc);

    rfu_crc_step u_crc (
        .crc_in  (crc_base),
        .data_in (in_byte),
        .crc_out (crc_nx)
    );

    rfu_lane_regs #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take_body && cur_word != '0),
        .wr_word (cur_word),
        .wr_pos  (cur_pos),
        .wr_byte (in_byte),
        .commit  (at_pad && crc_match),
        .samples (sample_bus)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        word_nx  = word_q;
        pos_nx   = pos_q;
        if (in_valid && in_sof) begin
            state_nx = ST_BODY;
            word_nx  = '0;
            pos_nx   = 2'd1;
        end else if (in_valid) begin
            unique case (state)
                ST_IDLE: ;
                ST_BODY: begin
                    if (pos_q == 2'd2) begin
                        pos_nx = 2'd0;
                        if (word_q == LAST_WORD) state_nx = ST_CRC_HI;
                        else                     word_nx  = word_q + 1'b1;
                    end else begin
                        pos_nx = pos_q + 2'd1;
                    end
                end
                ST_CRC_HI:  state_nx = ST_CRC_LO;
                ST_CRC_LO:  state_nx = ST_CRC_PAD;
                ST_CRC_PAD: state_nx = ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            word_q <= '0;
            pos_q  <= 2'd0;
        end else begin
            state  <= state_nx;
            word_q <= word_nx;
            pos_q  <= pos_nx;
        end
    end

    // datapath and output flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_acc       <= CRC_SEED;
            rx_hi         <= '0;
            rx_lo         <= '0;
            stat_shadow   <= '0;
            status_word   <= '0;
            frame_ok      <= 1'b0;
            frame_crc_bad <= 1'b0;
        end else begin
            frame_ok      <= 1'b0;
            frame_crc_bad <= 1'b0;
            if (take_body) begin
                crc_acc <= crc_nx;
                if (cur_word == '0 && cur_pos == 2'd0) stat_shadow[15:8] <= in_byte;
                if (cur_word == '0 && cur_pos == 2'd1) stat_shadow[7:0]  <= in_byte;
            end else if (in_valid && state == ST_CRC_HI) begin
                rx_hi <= in_byte;
            end else if (in_valid && state == ST_CRC_LO) begin
                rx_lo <= in_byte;
            end else if (at_pad) begin
                if (crc_match) begin
                    frame_ok    <= 1'b1;
                    status_word <= stat_shadow;
                end else begin
                    frame_crc_bad <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rfu_checker.sv
module rfu_checker #(
    parameter int NUM_CH = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_ok,
    input logic                 frame_crc_bad,
    input logic [NUM_CH*32-1:0] sample_bus,
    input logic [15:0]          status_word
);
    // R10: the two verdict flags exclude each other
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_crc_bad));

    // R5: a good-frame flag lasts a single cycle
    a_r5_ok_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);

    // R6: a failed frame leaves the published values untouched
    a_r6_hold_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        frame_crc_bad |-> ($stable(sample_bus) && $stable(status_word)));

    // R6: published samples move only together with a good-frame flag
    a_r6_change_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_bus != $past(sample_bus)) |-> frame_ok);

    // R7: status moves only together with a good-frame flag
    a_r7_status_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word != $past(status_word)) |-> frame_ok);
endmodule

bind rx_frame_unpacker rfu_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_ok      (frame_ok),
    .frame_crc_bad (frame_crc_bad),
    .sample_bus    (sample_bus),
    .status_word   (status_word)
);

// File: tb/rx_frame_unpacker_tb.sv
module rx_frame_unpacker_tb;
    localparam int NCH   = 4;
    localparam int FB    = (NCH + 2) * 3;
    localparam int CB    = (NCH + 1) * 3;
    localparam int CLK_P = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic [7:0]        in_byte = 8'h00;
    logic [NCH*32-1:0] sample_bus;
    logic [15:0]       status_word;
    logic              frame_ok, frame_crc_bad;

    rx_frame_unpacker #(.NUM_CH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_byte(in_byte), .sample_bus(sample_bus), .status_word(status_word),
        .frame_ok(frame_ok), .frame_crc_bad(frame_crc_bad)
    );

    always #(CLK_P/2) clk = ~clk;

    logic [7:0]  fb [FB];
    logic [23:0] cur_v [NCH];
    logic [23:0] exp_s [NCH];
    logic [15:0] exp_st = 16'h0;
    int          pend = 0;
    bit          pend_good = 1'b0;
    int          total = 0, fails = 0;
    int          cycles = 0;

    task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // bitwise serial CRC model over the covered bytes (R4)
    function automatic logic [15:0] ref_crc();
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < CB; i++)
            for (int b = 7; b >= 0; b--) begin
                logic fbk;
                fbk = fb[i][b] ^ c[15];
                c = c << 1;
                if (fbk) c = c ^ 16'h1021;
            end
        return c;
    endfunction

    function automatic logic [31:0] sext(input logic [23:0] v);
        return {{8{v[23]}}, v};
    endfunction

    task automatic check_outputs(input string tag);
        for (int c = 0; c < NCH; c++)
            chk(sample_bus[c*32 +: 32] == sext(exp_s[c]), {tag, " R2 R3 sample"},
                sample_bus[c*32 +: 32], sext(exp_s[c]));
        chk(status_word == exp_st, {tag, " R7 status"}, status_word, exp_st);
    endtask

    task automatic service();
        if (pend == 1) begin
            chk(frame_ok == pend_good, "R5 R4 frame_ok after last byte", frame_ok, pend_good);
            chk(frame_crc_bad == !pend_good, "R6 frame_crc_bad", frame_crc_bad, !pend_good);
            chk(!(frame_ok && frame_crc_bad), "R10 exclusive", {frame_ok, frame_crc_bad}, 0);
            check_outputs("verdict");
            pend = 2;
        end else if (pend == 2) begin
            chk(!frame_ok && !frame_crc_bad, "R5 single-cycle pulse", {frame_ok, frame_crc_bad}, 0);
            pend = 0;
        end
    endtask

    task automatic drive(input bit v, input bit s, input logic [7:0] d);
        @(negedge clk);
        service();
        in_valid = v;
        in_sof   = s;
        in_byte  = d;
    endtask

    task automatic build(input logic [15:0] st);
        logic [15:0] c;
        fb[0] = st[15:8];
        fb[1] = st[7:0];
        fb[2] = 8'($urandom);
        for (int k = 0; k < NCH; k++) begin
            fb[3+3*k] = cur_v[k][23:16];
            fb[4+3*k] = cur_v[k][15:8];
            fb[5+3*k] = cur_v[k][7:0];
        end
        c = ref_crc();
        fb[CB]   = c[15:8];
        fb[CB+1] = c[7:0];
        fb[CB+2] = 8'($urandom);
    endtask

    task automatic send(input bit corrupt, input int gapmax);
        if (corrupt) fb[CB + int'($urandom % 2)] ^= 8'(8'h01 << ($urandom % 8));
        for (int i = 0; i < FB; i++) begin
            if (gapmax > 0) begin
                int g = int'($urandom % (gapmax + 1));
                for (int k = 0; k < g; k++) drive(1'b0, 1'b0, 8'($urandom));
            end
            drive(1'b1, i == 0, fb[i]);
        end
        pend = 1;
        pend_good = !corrupt;
        if (!corrupt) begin
            for (int k = 0; k < NCH; k++) exp_s[k] = cur_v[k];
            exp_st = {fb[0], fb[1]};
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                total++;
                $display("FAIL watchdog R5 actual=%0d expected=done", cycles);
                $display("%0d/%0d checks passed", total - fails, total);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NCH; k++) exp_s[k] = 24'h0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!frame_ok && !frame_crc_bad, "R1 flags at reset", {frame_ok, frame_crc_bad}, 0);
        check_outputs("R1 reset");
        rst_n = 1'b1;

        // directed extremes, R3 sign extension
        cur_v[0] = 24'h7FFFFF; cur_v[1] = 24'h800000;
        cur_v[2] = 24'h000000; cur_v[3] = 24'hFFFFFF;
        build(16'h0500);
        send(1'b0, 0);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);

        // R7 status bit 12 set does not block publication
        for (int k = 0; k < NCH; k++) cur_v[k] = 24'($urandom);
        build(16'h1234);
        send(1'b0, 1);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);
        chk(status_word[12] == 1'b1, "R7 bit12 passed through", status_word, 16'h1234);

        // R6 corrupted received CRC keeps old values
        for (int k = 0; k < NCH; k++) cur_v[k] = 24'($urandom);
        build(16'h00AA);
        send(1'b1, 0);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);

        // R4 final pad byte is not checked
        for (int k = 0; k < NCH; k++) cur_v[k] = 24'($urandom);
        build(16'h0042);
        fb[FB-1] = ~fb[FB-1];
        send(1'b0, 0);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);

        // R9 stray bytes while idle are ignored
        for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, 8'($urandom));
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);
        chk(!frame_ok && !frame_crc_bad, "R9 no flag from stray bytes", {frame_ok, frame_crc_bad}, 0);
        check_outputs("R9 stray");

        // R8 restart in the middle of a frame
        for (int k = 0; k < NCH; k++) cur_v[k] = 24'($urandom);
        build(16'h0777);
        for (int i = 0; i < 7; i++) drive(1'b1, i == 0, fb[i]);
        for (int k = 0; k < NCH; k++) cur_v[k] = 24'($urandom);
        build(16'h0888);
        send(1'b0, 0);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);

        // random frames: back to back, with gaps (R9), some corrupted
        for (int n = 0; n < 60; n++) begin
            for (int k = 0; k < NCH; k++) cur_v[k] = 24'($urandom);
            build(16'($urandom));
            send(($urandom % 5) == 0, (n % 3 == 0) ? 2 : 0);
        end
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 8'h00);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule